// File: doc/BRIEF.md
# Conversion Sweep Sequencer with Result Queue

This block schedules conversions for a multi-input converter. A start command selects a mode and then walks a small table of setup entries. Each entry names a physical input channel and a word-rate code. For every setup visited, the block raises a request to an abstract converter and holds it until the converter answers with a done pulse and a 24-bit result. The result is tagged with the channel of its setup and pushed into a result queue. A host reads the queue through a serial port made of chip select, a bit-clock enable, serial in and serial out.

Four configuration inputs, latched at start, choose the mode. One selects between a single setup (picked by the command pointer) and a sweep over setups 0 to the depth value. One selects a single pass or endless repetition. One selects whether the host is told after every conversion or only after a full sweep. The depth value sets the sweep length. A read opens with eight bit clocks. During that prefix the serial output has already shown the ready state, and in repeat mode the byte the host shifts in decides whether conversions continue. Result words follow, most significant bit first.

Top module: `conv_sweep_seq`

## Requirements
- R1: After reset, `cnv_req` is low and `sdo` is high.
- R2: In single-setup mode (`cfg_multi`=0) the setup at index `cmd_ptr` is converted: its channel and rate appear on `cnv_chan`/`cnv_rate`, and they stay stable while `cnv_req` is held high until `cnv_done`.
- R3: In sweep mode (`cfg_multi`=1), setups 0 through `cfg_depth` are requested in ascending order and `cmd_ptr` has no effect.
- R4: Each queued word has the converter result bits 23:2 in bits 23:2. Bits 1:0 carry the channel indicator, which is the 2-bit channel field of the setup, where 0 to 3 stand for inputs 1 to 4. Setup entry k sits at `setup_tbl[5k+4:5k]`, with the channel in bits 1:0 and the rate in bits 4:2.
- R5: A read is eight prefix bit clocks followed by 24 bit clocks per word of the batch. After the prefix, `sdo` shows the word MSB first and advances one bit on each `sclk_en` pulse taken while `cs_n` is low.
- R6: With `cs_n` low and the port idle, `sdo` is 0 when a batch is available and 1 when none is. With `cs_n` high, `sdo` is 1.
- R7: With `cfg_rc`=1 in sweep mode a batch is the whole sweep, and it is flagged only once the last setup of that sweep has been converted. Otherwise a batch is one word, flagged after each conversion.
- R8: With `cfg_loop`=0 exactly one sweep (or one conversion in single-setup mode) is requested, after which `cnv_req` stays low.
- R9: With `cfg_loop`=1 conversions repeat. A prefix byte of 8'hFF stops requests at once and discards any conversion still in flight. It then transfers the current batch, empties the queue and returns the port to idle. Any other prefix byte lets conversions continue.
- R10: The queue holds 8 words. In repeat mode with `cs_n` high, a sweep that does not fit discards the oldest whole sweep, so a later read returns a complete sweep starting at setup 0.
- R11: While `cs_n` is low, a sweep that does not fit waits instead of discarding, and the queue never exceeds 8 words.
- R12: `cmd_go` has no effect while a sequence is running or a read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_go | input | 1 | Start pulse; latches mode and pointer |
| cmd_ptr | input | 3 | Setup index for single-setup mode |
| cfg_multi | input | 1 | 1 = sweep over setups 0..cfg_depth |
| cfg_loop | input | 1 | 1 = repeat until exit code |
| cfg_rc | input | 1 | 1 = flag only after a full sweep |
| cfg_depth | input | 3 | Last setup index of a sweep |
| setup_tbl | input | 40 | Eight setups of {rate[2:0], chan[1:0]} |
| cnv_req | output | 1 | Conversion request, held until done |
| cnv_chan | output | 2 | Channel of the requested setup |
| cnv_rate | output | 3 | Word-rate code of the requested setup |
| cnv_done | input | 1 | Conversion finished, result valid |
| cnv_data | input | 24 | Conversion result |
| cs_n | input | 1 | Active-low port select |
| sclk_en | input | 1 | One-cycle serial bit-clock pulse |
| sdi | input | 1 | Serial data in (prefix byte) |
| sdo | output | 1 | Ready flag, then result bits |

## Verification
A wrong sweep index or pointer shows up on `cnv_chan`/`cnv_rate` at the very next request. A mis-tagged or mis-ordered queue entry shows up in the first read that reaches that word. A queue that drops the wrong number of words on overrun shows up as a batch that starts at a setup other than 0, but only in the read that follows a long period with `cs_n` high. A missed exit shows up within one conversion latency as a new rise of `cnv_req`, or as `sdo` staying low with `cs_n` low after the final word.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
   localparam int         PFX_LEN   = 8;
   localparam logic [7:0] EXIT_CODE = 8'hFF;

   typedef enum logic [1:0] {CT_IDLE, CT_ISSUE, CT_WAIT} ctl_state_t;
   typedef enum logic [1:0] {SP_FLAG, SP_PFX, SP_DATA} sp_state_t;
endpackage

// File: rtl/cseq_fifo.sv
module cseq_fifo #(
   parameter int W     = 24,
   parameter int DEPTH = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       push,
   input  logic [W-1:0]               wdata,
   input  logic                       pop,
   input  logic                       drop,
   input  logic [$clog2(DEPTH+1)-1:0] drop_n,
   output logic [W-1:0]               rdata,
   output logic [$clog2(DEPTH+1)-1:0] count
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("cseq_fifo: DEPTH must be a power of two >= 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rd_ptr, wr_ptr;
   logic [CW-1:0] drop_amt;

   assign drop_amt = drop ? drop_n : '0;
   assign rdata    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + AW'(1);
         rd_ptr <= rd_ptr + AW'(pop) + drop_amt[AW-1:0];
         count  <= count + CW'(push) - CW'(pop) - drop_amt;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !flush && count == CW'(DEPTH)) |-> pop); // R11
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count != '0)); // R5
endmodule

// File: rtl/cseq_ctrl.sv
module cseq_ctrl
   import cseq_pkg::*;
#(
   parameter int NSETUP     = 8,
   parameter int CHW        = 2,
   parameter int RW         = 3,
   parameter int DW         = 24,
   parameter int FIFO_DEPTH = 8,
   parameter bit OVERWRITE  = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            go,
   input  logic                            cfg_multi,
   input  logic                            cfg_loop,
   input  logic                            cfg_rc,
   input  logic [$clog2(NSETUP)-1:0]       cfg_depth,
   input  logic [$clog2(NSETUP)-1:0]       cmd_ptr,
   input  logic [NSETUP*(CHW+RW)-1:0]      setup_tbl,
   input  logic                            port_busy,
   input  logic                            cs_n,
   input  logic                            exit_req,
   input  logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_count,
   output logic                            cnv_req,
   output logic [CHW-1:0]                  cnv_chan,
   output logic [RW-1:0]                   cnv_rate,
   input  logic                            cnv_done,
   input  logic [DW-1:0]                   cnv_data,
   output logic                            push,
   output logic [DW-1:0]                   push_word,
   output logic                            flush,
   output logic                            drop,
   output logic [$clog2(FIFO_DEPTH+1)-1:0] sweep_len,
   output logic [$clog2(FIFO_DEPTH+1)-1:0] batch_len,
   output logic                            loop_on
);
   localparam int IW   = $clog2(NSETUP);
   localparam int SETW = CHW + RW;
   localparam int CW   = $clog2(FIFO_DEPTH+1);

   ctl_state_t      st;
   logic            multi_q, loop_q, rc_q, req_q;
   logic [IW-1:0]   depth_q, ptr_q, idx_q, sel;
   logic [SETW-1:0] cur;
   logic            at_last, room_ok, need_room, can_drop, issue_ok, go_ok;

   assign sel       = multi_q ? idx_q : ptr_q;
   assign cur       = setup_tbl[int'(sel)*SETW +: SETW];
   assign cnv_chan  = cur[CHW-1:0];
   assign cnv_rate  = cur[SETW-1:CHW];
   assign cnv_req   = req_q;
   assign loop_on   = loop_q;
   assign at_last   = !multi_q || (idx_q == depth_q);
   assign sweep_len = multi_q ? CW'(depth_q) + CW'(1) : CW'(1);
   assign batch_len = (multi_q && rc_q) ? sweep_len : CW'(1);
   assign room_ok   = ({1'b0, fifo_count} + {1'b0, sweep_len}) <= (CW+1)'(FIFO_DEPTH);
   assign need_room = (st == CT_ISSUE) && (idx_q == '0) && !room_ok;

   if (OVERWRITE) begin : g_overwrite
      assign can_drop = cs_n;
   end else begin : g_stall
      assign can_drop = 1'b0;
   end

   assign drop      = need_room && can_drop && !exit_req;
   assign issue_ok  = (st == CT_ISSUE) && (!need_room || can_drop);
   assign go_ok     = go && (st == CT_IDLE) && !port_busy;
   assign flush     = go_ok;
   assign push      = (st == CT_WAIT) && cnv_done && !exit_req;
   assign push_word = {cnv_data[DW-1:CHW], cnv_chan};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= CT_IDLE;
         multi_q <= 1'b0;
         loop_q  <= 1'b0;
         rc_q    <= 1'b0;
         req_q   <= 1'b0;
         depth_q <= '0;
         ptr_q   <= '0;
         idx_q   <= '0;
      end else if (exit_req) begin
         st     <= CT_IDLE;
         req_q  <= 1'b0;
         loop_q <= 1'b0;
      end else begin
         unique case (st)
            CT_IDLE: if (go_ok) begin
               multi_q <= cfg_multi;
               loop_q  <= cfg_loop;
               rc_q    <= cfg_rc;
               depth_q <= cfg_depth;
               ptr_q   <= cmd_ptr;
               idx_q   <= '0;
               st      <= CT_ISSUE;
            end
            CT_ISSUE: if (issue_ok) begin
               req_q <= 1'b1;
               st    <= CT_WAIT;
            end
            CT_WAIT: if (cnv_done) begin
               req_q <= 1'b0;
               if (at_last) begin
                  idx_q <= '0;
                  st    <= loop_q ? CT_ISSUE : CT_IDLE;
               end else begin
                  idx_q <= idx_q + IW'(1);
                  st    <= CT_ISSUE;
               end
            end
            default: st <= CT_IDLE;
         endcase
      end
   end

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q && !cnv_done && !exit_req) |=> (req_q && $stable(cnv_chan) && $stable(cnv_rate))); // R2
   AST_EXIT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      exit_req |=> !req_q); // R9
   AST_SWEEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q && multi_q) |-> (idx_q <= depth_q)); // R3
endmodule

// File: rtl/cseq_sport.sv
module cseq_sport
   import cseq_pkg::*;
#(
   parameter int DW         = 24,
   parameter int FIFO_DEPTH = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cs_n,
   input  logic                            sclk_en,
   input  logic                            sdi,
   output logic                            sdo,
   input  logic                            loop_on,
   input  logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_count,
   input  logic [$clog2(FIFO_DEPTH+1)-1:0] batch_len,
   input  logic [DW-1:0]                   fifo_rdata,
   output logic                            pop,
   output logic                            exit_req,
   output logic                            flush,
   output logic                            busy
);
   localparam int CW = $clog2(FIFO_DEPTH+1);
   localparam int BW = $clog2(DW);

   if (DW < PFX_LEN) begin : g_bad_width
      $error("cseq_sport: DW must be at least the prefix length");
   end

   sp_state_t           st;
   logic [BW-1:0]       bcnt;
   logic [PFX_LEN-2:0]  pfx_sr;
   logic [DW-1:0]       sh;
   logic [CW-1:0]       wleft;
   logic                exit_q, tick, ready, pfx_end, word_end;

   assign tick     = sclk_en && !cs_n;
   assign ready    = (fifo_count != '0) && (fifo_count >= batch_len);
   assign pfx_end  = (st == SP_PFX) && tick && (bcnt == BW'(PFX_LEN-1));
   assign word_end = (st == SP_DATA) && tick && (bcnt == BW'(DW-1));
   assign pop      = pfx_end || (word_end && wleft != CW'(1));
   assign exit_req = pfx_end && loop_on && ({pfx_sr, sdi} == EXIT_CODE);
   assign flush    = word_end && (wleft == CW'(1)) && exit_q;
   assign busy     = (st != SP_FLAG);

   always_comb begin
      if (cs_n)                 sdo = 1'b1;
      else if (st == SP_FLAG)   sdo = !ready;
      else if (st == SP_PFX)    sdo = 1'b0;
      else                      sdo = sh[DW-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SP_FLAG;
         bcnt   <= '0;
         pfx_sr <= '0;
         sh     <= '0;
         wleft  <= '0;
         exit_q <= 1'b0;
      end else if (cs_n) begin
         st     <= SP_FLAG;
         bcnt   <= '0;
         exit_q <= 1'b0;
      end else begin
         unique case (st)
            SP_FLAG: if (tick && ready) begin
               st     <= SP_PFX;
               pfx_sr <= {{(PFX_LEN-2){1'b0}}, sdi};
               bcnt   <= BW'(1);
            end
            SP_PFX: if (tick) begin
               pfx_sr <= {pfx_sr[PFX_LEN-3:0], sdi};
               bcnt   <= bcnt + BW'(1);
               if (pfx_end) begin
                  st     <= SP_DATA;
                  sh     <= fifo_rdata;
                  bcnt   <= '0;
                  wleft  <= batch_len;
                  exit_q <= exit_req;
               end
            end
            SP_DATA: if (tick) begin
               if (word_end) begin
                  bcnt <= '0;
                  if (wleft == CW'(1)) begin
                     st     <= SP_FLAG;
                     exit_q <= 1'b0;
                  end else begin
                     sh    <= fifo_rdata;
                     wleft <= wleft - CW'(1);
                  end
               end else begin
                  sh   <= {sh[DW-2:0], 1'b0};
                  bcnt <= bcnt + BW'(1);
               end
            end
            default: st <= SP_FLAG;
         endcase
      end
   end

   AST_BATCH_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
      pfx_end |-> (fifo_count >= batch_len)); // R7
endmodule

// File: rtl/conv_sweep_seq.sv
module conv_sweep_seq #(
   parameter int NSETUP     = 8,
   parameter int CHW        = 2,
   parameter int RW         = 3,
   parameter int DW         = 24,
   parameter int FIFO_DEPTH = 8,
   parameter bit OVERWRITE  = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cmd_go,
   input  logic [$clog2(NSETUP)-1:0]    cmd_ptr,
   input  logic                         cfg_multi,
   input  logic                         cfg_loop,
   input  logic                         cfg_rc,
   input  logic [$clog2(NSETUP)-1:0]    cfg_depth,
   input  logic [NSETUP*(CHW+RW)-1:0]   setup_tbl,
   output logic                         cnv_req,
   output logic [CHW-1:0]               cnv_chan,
   output logic [RW-1:0]                cnv_rate,
   input  logic                         cnv_done,
   input  logic [DW-1:0]                cnv_data,
   input  logic                         cs_n,
   input  logic                         sclk_en,
   input  logic                         sdi,
   output logic                         sdo
);
   localparam int CW = $clog2(FIFO_DEPTH+1);

   if (NSETUP > FIFO_DEPTH) begin : g_bad_fit
      $error("conv_sweep_seq: a full sweep must fit in the queue");
   end
   if (DW <= CHW) begin : g_bad_dw
      $error("conv_sweep_seq: result width must exceed tag width");
   end

   logic          push, pop, drop, flush_c, flush_s, exit_req, loop_on, port_busy;
   logic [DW-1:0] push_word, rdata;
   logic [CW-1:0] count, sweep_len, batch_len;

   cseq_ctrl #(
      .NSETUP(NSETUP), .CHW(CHW), .RW(RW), .DW(DW),
      .FIFO_DEPTH(FIFO_DEPTH), .OVERWRITE(OVERWRITE)
   ) ctrl_i (
      .clk(clk), .rst_n(rst_n), .go(cmd_go),
      .cfg_multi(cfg_multi), .cfg_loop(cfg_loop), .cfg_rc(cfg_rc),
      .cfg_depth(cfg_depth), .cmd_ptr(cmd_ptr), .setup_tbl(setup_tbl),
      .port_busy(port_busy), .cs_n(cs_n), .exit_req(exit_req),
      .fifo_count(count), .cnv_req(cnv_req), .cnv_chan(cnv_chan),
      .cnv_rate(cnv_rate), .cnv_done(cnv_done), .cnv_data(cnv_data),
      .push(push), .push_word(push_word), .flush(flush_c), .drop(drop),
      .sweep_len(sweep_len), .batch_len(batch_len), .loop_on(loop_on)
   );

   cseq_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) fifo_i (
      .clk(clk), .rst_n(rst_n), .flush(flush_c | flush_s),
      .push(push), .wdata(push_word), .pop(pop),
      .drop(drop), .drop_n(sweep_len), .rdata(rdata), .count(count)
   );

   cseq_sport #(.DW(DW), .FIFO_DEPTH(FIFO_DEPTH)) sport_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_en(sclk_en),
      .sdi(sdi), .sdo(sdo), .loop_on(loop_on), .fifo_count(count),
      .batch_len(batch_len), .fifo_rdata(rdata), .pop(pop),
      .exit_req(exit_req), .flush(flush_s), .busy(port_busy)
   );
endmodule

// File: tb/conv_sweep_seq_tb_top.sv
module conv_sweep_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_go = 1'b0;
   logic [2:0]  cmd_ptr = '0;
   logic        cfg_multi = 1'b0, cfg_loop = 1'b0, cfg_rc = 1'b0;
   logic [2:0]  cfg_depth = '0;
   logic [39:0] setup_tbl = '0;
   logic        cnv_req;
   logic [1:0]  cnv_chan;
   logic [2:0]  cnv_rate;
   logic        cnv_done = 1'b0;
   logic [23:0] cnv_data = '0;
   logic        cs_n = 1'b1, sclk_en = 1'b0, sdi = 1'b0;
   logic        sdo;

   int nchk = 0, nerr = 0;
   int nreq = 0, ndone = 0;
   logic [4:0]  reqlog [1024];
   logic [23:0] rb [8];
   int lat;
   bit ok_run;

   always #2 clk = ~clk;

   conv_sweep_seq dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_ptr(cmd_ptr),
      .cfg_multi(cfg_multi), .cfg_loop(cfg_loop), .cfg_rc(cfg_rc),
      .cfg_depth(cfg_depth), .setup_tbl(setup_tbl), .cnv_req(cnv_req),
      .cnv_chan(cnv_chan), .cnv_rate(cnv_rate), .cnv_done(cnv_done),
      .cnv_data(cnv_data), .cs_n(cs_n), .sclk_en(sclk_en), .sdi(sdi), .sdo(sdo)
   );

   function automatic logic [23:0] mval(logic [1:0] ch, logic [2:0] rt);
      return {2'b10, ch, 1'b0, rt, 8'hA5, 2'b01, ~ch, 1'b1, ~rt};
   endfunction
   function automatic logic [1:0] ch_of(int i);
      return setup_tbl[i*5 +: 2];
   endfunction
   function automatic logic [2:0] rt_of(int i);
      return setup_tbl[i*5+2 +: 3];
   endfunction
   function automatic logic [23:0] expw(int i);
      logic [23:0] v;
      v = mval(ch_of(i), rt_of(i));
      return {v[23:2], ch_of(i)};
   endfunction

   // behavioural converter: answers after a random latency, aborts if request drops
   always begin
      @(negedge clk);
      if (cnv_req) begin
         reqlog[nreq % 1024] = {cnv_rate, cnv_chan};
         nreq++;
         lat = $urandom_range(5, 2);
         ok_run = 1'b1;
         for (int k = 0; k < lat; k++) begin
            @(negedge clk);
            if (!cnv_req) ok_run = 1'b0;
         end
         if (ok_run && cnv_req) begin
            cnv_data = mval(cnv_chan, cnv_rate);
            cnv_done = 1'b1;
            ndone++;
            @(negedge clk);
            cnv_done = 1'b0;
         end
      end
   end

   task automatic chk(string tag, logic [23:0] act, logic [23:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick(logic b);
      @(negedge clk);
      sdi = b;
      sclk_en = 1'b1;
      @(negedge clk);
      sclk_en = 1'b0;
   endtask

   task automatic wait_flag(output bit got);
      got = 1'b0;
      cs_n = 1'b0;
      for (int i = 0; i < 3000 && !got; i++) begin
         @(negedge clk);
         if (sdo == 1'b0) got = 1'b1;
      end
   endtask

   task automatic read_batch(logic [7:0] pfx, int n);
      logic [23:0] w;
      for (int i = 0; i < 8; i++) tick(pfx[7-i]);
      for (int k = 0; k < n; k++) begin
         w = '0;
         for (int b = 0; b < 24; b++) begin
            w = {w[22:0], sdo};
            tick(1'b0);
         end
         rb[k] = w;
      end
   endtask

   task automatic start(logic m, logic l, logic r, logic [2:0] d, logic [2:0] p);
      @(negedge clk);
      cfg_multi = m; cfg_loop = l; cfg_rc = r; cfg_depth = d; cmd_ptr = p;
      cmd_go = 1'b1;
      @(negedge clk);
      cmd_go = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      bit got;
      int base, n1;
      void'($urandom(32'd7321));
      for (int i = 0; i < 8; i++) setup_tbl[i*5 +: 5] = {3'(i), 2'($urandom_range(3, 0))};

      repeat (5) @(negedge clk);
      chk("R1 sdo after reset", 24'(sdo), 24'd1);
      chk("R1 req after reset", 24'(cnv_req), 24'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      cs_n = 1'b0;
      @(negedge clk);
      chk("R6 flag high with empty queue", 24'(sdo), 24'd1);
      cs_n = 1'b1;

      // single-setup single-shot
      base = nreq;
      start(1'b0, 1'b0, 1'b0, 3'd6, 3'd5);
      wait_flag(got);
      chk("R6 flag low when ready", 24'(got), 24'd1);
      chk("R2 requested setup", 24'(reqlog[base % 1024]), 24'({rt_of(5), ch_of(5)}));
      read_batch(8'h00, 1);
      chk("R4 R5 single word", rb[0], expw(5));
      repeat (100) @(negedge clk);
      chk("R8 one conversion only", 24'(nreq - base), 24'd1);
      chk("R6 flag high after drain", 24'(sdo), 24'd1);
      cs_n = 1'b1;
      @(negedge clk);
      chk("R6 flag high with cs released", 24'(sdo), 24'd1);

      // sweep, whole-sweep batch
      base = nreq;
      n1 = ndone;
      start(1'b1, 1'b0, 1'b1, 3'd3, 3'd6);
      cs_n = 1'b0;
      while (ndone == n1) @(negedge clk);
      repeat (3) @(negedge clk);
      chk("R7 no flag mid sweep", 24'(sdo), 24'd1);
      wait_flag(got);
      chk("R7 flag after full sweep", 24'(ndone - n1), 24'd4);
      read_batch(8'h00, 4);
      for (int i = 0; i < 4; i++) begin
         chk("R3 sweep word order", rb[i], expw(i));
         chk("R3 request order", 24'(reqlog[(base + i) % 1024]), 24'({rt_of(i), ch_of(i)}));
      end
      repeat (100) @(negedge clk);
      chk("R8 single sweep only", 24'(nreq - base), 24'd4);
      cs_n = 1'b1;

      // sweep, per-conversion batch
      start(1'b1, 1'b0, 1'b0, 3'd2, 3'd0);
      for (int k = 0; k < 3; k++) begin
         wait_flag(got);
         read_batch(8'h00, 1);
         chk("R7 per-conversion batch", rb[0], expw(k));
      end
      cs_n = 1'b1;

      // repeat, single setup, continue then exit
      start(1'b0, 1'b1, 1'b0, 3'd0, 3'd2);
      for (int k = 0; k < 3; k++) begin
         wait_flag(got);
         read_batch((k == 0) ? 8'h00 : 8'($urandom_range(254, 0)), 1);
         chk("R9 continue keeps running", rb[0], expw(2));
      end
      start(1'b1, 1'b0, 1'b0, 3'd7, 3'd4);
      base = nreq;
      repeat (40) @(negedge clk);
      wait_flag(got);
      read_batch(8'h00, 1);
      chk("R12 go ignored while running", rb[0], expw(2));
      chk("R12 later requests unchanged", 24'(reqlog[base % 1024]), 24'({rt_of(2), ch_of(2)}));
      wait_flag(got);
      read_batch(8'hFF, 1);
      chk("R9 last word after exit", rb[0], expw(2));
      repeat (20) @(negedge clk);
      n1 = nreq;
      repeat (100) @(negedge clk);
      chk("R9 no requests after exit", 24'(nreq - n1), 24'd0);
      chk("R9 queue emptied after exit", 24'(sdo), 24'd1);
      cs_n = 1'b1;

      // repeat sweep with overrun while deselected
      base = nreq;
      start(1'b1, 1'b1, 1'b1, 3'd1, 3'd0);
      repeat (600) @(negedge clk);
      chk("R10 kept converting on overrun", 24'(nreq - base > 10), 24'd1);
      wait_flag(got);
      read_batch(8'h00, 2);
      chk("R10 aligned sweep word 0", rb[0], expw(0));
      chk("R10 aligned sweep word 1", rb[1], expw(1));
      wait_flag(got);
      read_batch(8'hFF, 2);
      chk("R9 exit batch word 0", rb[0], expw(0));
      chk("R9 exit batch word 1", rb[1], expw(1));
      repeat (30) @(negedge clk);
      chk("R9 idle after exit", 24'(sdo), 24'd1);
      cs_n = 1'b1;

      // repeat sweep stalls while selected
      base = nreq;
      @(negedge clk);
      cs_n = 1'b0;
      start(1'b1, 1'b1, 1'b1, 3'd2, 3'd0);
      repeat (600) @(negedge clk);
      chk("R11 stall while selected", 24'(nreq - base), 24'd6);
      read_batch(8'h00, 3);
      for (int i = 0; i < 3; i++) chk("R11 first sweep kept", rb[i], expw(i));
      wait_flag(got);
      read_batch(8'hFF, 3);
      for (int i = 0; i < 3; i++) chk("R11 second sweep kept", rb[i], expw(i));
      cs_n = 1'b1;

      // random single-shot episodes
      for (int r = 0; r < 6; r++) begin
         logic m, rc;
         logic [2:0] d, p;
         int nw, bl;
         m = 1'($urandom_range(1, 0));
         rc = 1'($urandom_range(1, 0));
         d = 3'($urandom_range(7, 0));
         p = 3'($urandom_range(7, 0));
         nw = m ? int'(d) + 1 : 1;
         bl = (m && rc) ? nw : 1;
         start(m, 1'b0, rc, d, p);
         for (int w = 0; w < nw; w += bl) begin
            wait_flag(got);
            read_batch(8'($urandom_range(255, 0)), bl);
            for (int i = 0; i < bl; i++)
               chk("R3 R4 random episode", rb[i], m ? expw(w + i) : expw(int'(p)));
         end
         cs_n = 1'b1;
         @(negedge clk);
      end

      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule